// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block lets a host move bytes between a narrow data port and an internal packet buffer without addressing each location itself. The host programs a 16-bit start address and a 16-bit byte count through byte-wide registers and then issues a command that selects a read or write direction. From then on, each strobe on the data port moves one byte, or one 16-bit word when word mode is selected. Each strobe also steps the address up and the count down.

When the count runs out, the transfer closes and a sticky completion flag is raised. The host clears this flag by writing a 1 to it. In word mode the engine rounds an odd byte count up to the next even value when the transfer starts. An abort command ends a transfer early and leaves the address and the count where they stopped.

Top module: `rdma_port_engine`

## Requirements
- R1: After reset the address and count read back as 0, the status register reads 0, `xfer_ready` and `xfer_done` are low, and `dp_rdata` is 0.
- R2: Register select 0/1 writes the low/high byte of the address and select 2/3 the low/high byte of the count. Reading these selects returns the current bytes of the live address and count.
- R3: The command register is at select 4. Bits [1:0] equal to 01 mean read, 10 means write, and 00 or 11 means abort. Bit 2 is the start bit. A read or write without bit 2 set has no effect.
- R4: If word mode is high at start, an odd count is rounded up to the next even value, modulo 2^16. The mode is held for the whole transfer.
- R5: Each accepted access moves one byte in byte mode, or two bytes in word mode, with the low byte at the current address. Read data is {8'h00, byte} in byte mode and {byte at addr+1, byte at addr} in word mode. After the access the address rises by the access width and the count falls by the same amount.
- R6: When the count reaches zero, the transfer ends and the done flag is set. The done flag is bit 0 of status select 5 and also appears on `xfer_done`. A start with a zero count sets done at once.
- R7: Writing status select 5 with bit 0 = 1 clears done, and bit 0 = 0 leaves it unchanged. If done is set in the same cycle as a clear, the set wins.
- R8: A data-port access that comes with no active transfer, or in the direction opposite to the active one, is ignored. The address, the count and the buffer stay unchanged.
- R9: Status bit 1 and `xfer_ready` are high exactly while a transfer is active, which implies the count is nonzero.
- R10: An abort ends the active transfer. It keeps the address and count as they are and does not set done.
- R11: Writes to the address and count registers are ignored while a transfer is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_mode | input | 1 | Selects 16-bit accesses at transfer start |
| reg_sel | input | 3 | Register select |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_sel` |
| dp_rd | input | 1 | Data-port read strobe |
| dp_wr | input | 1 | Data-port write strobe |
| dp_wdata | input | 16 | Data-port write data |
| dp_rdata | output | 16 | Data-port read data at the current address |
| xfer_ready | output | 1 | A transfer is active |
| xfer_done | output | 1 | Sticky completion flag |

## Verification
The buffer is filled by a byte-mode write and a word-mode write and is then read back in both widths. These passes separate a correct byte-lane order from swapped lanes and show whether the address steps by 1 or by 2. An odd count is started in word mode to tell rounding apart from truncation. Strobes are also sent after completion, in the wrong direction and after a command without its start bit; each of these must leave the address and count unchanged. The abort case, the zero-count case and the register lock during a transfer each show whether done is raised, and whether the transfer state survives, only when it should.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  localparam int RDMA_W = 16;

  typedef enum logic [1:0] {
    XF_IDLE  = 2'b00,
    XF_READ  = 2'b01,
    XF_WRITE = 2'b10
  } xfer_op_t;

  localparam logic [2:0] SEL_ADDR_LO = 3'd0;
  localparam logic [2:0] SEL_ADDR_HI = 3'd1;
  localparam logic [2:0] SEL_CNT_LO  = 3'd2;
  localparam logic [2:0] SEL_CNT_HI  = 3'd3;
  localparam logic [2:0] SEL_CMD     = 3'd4;
  localparam logic [2:0] SEL_STAT    = 3'd5;

  // Count seen by a new transfer: odd values round up in word mode.
  function automatic logic [RDMA_W-1:0] round_count(input logic [RDMA_W-1:0] c,
                                                    input logic wide);
    return wide ? c + {{(RDMA_W-1){1'b0}}, c[0]} : c;
  endfunction

  // Bytes moved by one data-port access.
  function automatic logic [RDMA_W-1:0] access_step(input logic wide);
    return wide ? RDMA_W'(2) : RDMA_W'(1);
  endfunction
endpackage

// File: rtl/rdma_buf_ram.sv
module rdma_buf_ram #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic          we_lo,
  input  logic          we_hi,
  input  logic [15:0]   wdata,
  output logic [15:0]   rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] addr_nx;

  assign addr_nx = addr + 1'b1;
  assign rdata   = {mem[addr_nx], mem[addr]};

  always_ff @(posedge clk) begin
    if (we_lo) mem[addr]    <= wdata[7:0];
    if (we_hi) mem[addr_nx] <= wdata[15:8];
  end
endmodule

// File: rtl/rdma_xfer_ctrl.sv
module rdma_xfer_ctrl
  import rdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_req,
  input  logic              ld_addr_lo,
  input  logic              ld_addr_hi,
  input  logic              ld_cnt_lo,
  input  logic              ld_cnt_hi,
  input  logic              cmd_wr,
  input  logic              clr_done,
  input  logic [7:0]        wdata,
  input  logic              acc_rd,
  input  logic              acc_wr,
  output logic [RDMA_W-1:0] addr_q,
  output logic [RDMA_W-1:0] cnt_q,
  output xfer_op_t          op_q,
  output logic              wide_q,
  output logic              done_q,
  output logic              move,
  output logic              move_wr
);
  logic              is_rd, is_wr, launch, abort, active, last, done_set;
  logic [RDMA_W-1:0] launch_cnt, step;

  assign is_rd      = wdata[1:0] == 2'b01;
  assign is_wr      = wdata[1:0] == 2'b10;
  assign launch     = cmd_wr && (is_rd || is_wr) && wdata[2];
  assign abort      = cmd_wr && !(is_rd || is_wr);
  assign launch_cnt = round_count(cnt_q, wide_req);
  assign active     = op_q != XF_IDLE;
  assign step       = access_step(wide_q);
  assign move       = (op_q == XF_READ && acc_rd) || (op_q == XF_WRITE && acc_wr);
  assign move_wr    = move && op_q == XF_WRITE;
  assign last       = move && cnt_q == step;
  assign done_set   = last || (launch && launch_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      op_q   <= XF_IDLE;
      wide_q <= 1'b0;
    end else begin
      if (!active) begin
        if (ld_addr_lo) addr_q[7:0]          <= wdata;
        if (ld_addr_hi) addr_q[RDMA_W-1:8]   <= wdata;
        if (ld_cnt_lo)  cnt_q[7:0]           <= wdata;
        if (ld_cnt_hi)  cnt_q[RDMA_W-1:8]    <= wdata;
      end
      if (launch) begin
        cnt_q  <= launch_cnt;
        wide_q <= wide_req;
        if (launch_cnt == '0) op_q <= XF_IDLE;
        else                  op_q <= is_rd ? XF_READ : XF_WRITE;
      end else if (abort) begin
        op_q <= XF_IDLE;
      end else if (move) begin
        addr_q <= addr_q + step;
        cnt_q  <= cnt_q - step;
        if (last) op_q <= XF_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        done_q <= 1'b0;
    else if (done_set) done_q <= 1'b1;
    else if (clr_done) done_q <= 1'b0;
  end

  a_r5_addr_advance: assert property (@(posedge clk) disable iff (!rst_n)
    move |=> addr_q == $past(addr_q) + $past(step));
  a_r5_cnt_drop: assert property (@(posedge clk) disable iff (!rst_n)
    move |=> cnt_q == $past(cnt_q) - $past(step));
  a_r6_done_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (done_q && op_q == XF_IDLE && cnt_q == '0));
  a_r9_active_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q != XF_IDLE) |-> cnt_q != '0);
  a_r4_word_even: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q != XF_IDLE && wide_q) |-> !cnt_q[0]);
  a_r10_abort_stops: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (op_q == XF_IDLE && $stable(cnt_q) && $stable(addr_q)));
  a_r7_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_done && !done_set) |=> !done_q);
  a_r11_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !move) |=> $stable(addr_q));
endmodule

// File: rtl/rdma_port_engine.sv
module rdma_port_engine
  import rdma_pkg::*;
#(
  parameter int MEM_AW = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        word_mode,
  input  logic [2:0]  reg_sel,
  input  logic        reg_we,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        dp_rd,
  input  logic        dp_wr,
  input  logic [15:0] dp_wdata,
  output logic [15:0] dp_rdata,
  output logic        xfer_ready,
  output logic        xfer_done
);
  logic [RDMA_W-1:0] addr_q, cnt_q;
  xfer_op_t          op_q;
  logic              wide_q, done_q, move, move_wr;
  logic [15:0]       ram_rdata;
  logic              ram_we_lo, ram_we_hi;

  rdma_xfer_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wide_req   (word_mode),
    .ld_addr_lo (reg_we && reg_sel == SEL_ADDR_LO),
    .ld_addr_hi (reg_we && reg_sel == SEL_ADDR_HI),
    .ld_cnt_lo  (reg_we && reg_sel == SEL_CNT_LO),
    .ld_cnt_hi  (reg_we && reg_sel == SEL_CNT_HI),
    .cmd_wr     (reg_we && reg_sel == SEL_CMD),
    .clr_done   (reg_we && reg_sel == SEL_STAT && reg_wdata[0]),
    .wdata      (reg_wdata),
    .acc_rd     (dp_rd),
    .acc_wr     (dp_wr),
    .addr_q     (addr_q),
    .cnt_q      (cnt_q),
    .op_q       (op_q),
    .wide_q     (wide_q),
    .done_q     (done_q),
    .move       (move),
    .move_wr    (move_wr)
  );

  assign ram_we_lo = move_wr;
  assign ram_we_hi = move_wr && wide_q;

  rdma_buf_ram #(.AW(MEM_AW)) u_ram (
    .clk   (clk),
    .addr  (addr_q[MEM_AW-1:0]),
    .we_lo (ram_we_lo),
    .we_hi (ram_we_hi),
    .wdata (dp_wdata),
    .rdata (ram_rdata)
  );

  assign xfer_ready = op_q != XF_IDLE;
  assign xfer_done  = done_q;

  always_comb begin
    if (op_q == XF_READ) dp_rdata = wide_q ? ram_rdata : {8'h00, ram_rdata[7:0]};
    else                 dp_rdata = 16'h0000;
  end

  always_comb begin
    case (reg_sel)
      SEL_ADDR_LO: reg_rdata = addr_q[7:0];
      SEL_ADDR_HI: reg_rdata = addr_q[RDMA_W-1:8];
      SEL_CNT_LO:  reg_rdata = cnt_q[7:0];
      SEL_CNT_HI:  reg_rdata = cnt_q[RDMA_W-1:8];
      SEL_CMD:     reg_rdata = {6'b0, op_q};
      SEL_STAT:    reg_rdata = {6'b0, xfer_ready, done_q};
      default:     reg_rdata = 8'h00;
    endcase
  end

  a_r8_no_store_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_ready |-> !(ram_we_lo || ram_we_hi));
  a_r8_stray_access: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_ready && !reg_we) |=> ($stable(addr_q) && $stable(cnt_q)));
  a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !(reg_we && reg_sel == SEL_STAT && reg_wdata[0])) |=> xfer_done);
endmodule

// File: tb/rdma_port_engine_bench.sv
`timescale 1ns/100ps
module rdma_port_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_mode = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic        dp_rd = 1'b0, dp_wr = 1'b0;
  logic [15:0] dp_wdata = 16'h0000;
  logic [15:0] dp_rdata;
  logic        xfer_ready, xfer_done;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rdma_port_engine u_rdma_port_engine (
    .clk(clk), .rst_n(rst_n), .word_mode(word_mode),
    .reg_sel(reg_sel), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dp_rd(dp_rd), .dp_wr(dp_wr), .dp_wdata(dp_wdata), .dp_rdata(dp_rdata),
    .xfer_ready(xfer_ready), .xfer_done(xfer_done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] sel, input logic [7:0] d);
    reg_sel = sel; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] sel, output logic [7:0] v);
    reg_sel = sel; #1; v = reg_rdata;
  endtask

  task automatic rd16(input logic [2:0] lo_sel, output logic [15:0] v);
    logic [7:0] lo, hi;
    reg_rd(lo_sel, lo); reg_rd(lo_sel + 3'd1, hi);
    v = {hi, lo};
    @(negedge clk);
  endtask

  task automatic setup(input logic [15:0] a, input logic [15:0] c);
    reg_wr(3'd0, a[7:0]); reg_wr(3'd1, a[15:8]);
    reg_wr(3'd2, c[7:0]); reg_wr(3'd3, c[15:8]);
  endtask

  task automatic dp_read(output logic [15:0] v);
    #1; v = dp_rdata;
    dp_rd = 1'b1; @(negedge clk); dp_rd = 1'b0;
  endtask

  task automatic dp_write(input logic [15:0] d);
    dp_wdata = d; dp_wr = 1'b1; @(negedge clk); dp_wr = 1'b0;
  endtask

  task automatic status(output logic [7:0] v);
    reg_rd(3'd5, v); @(negedge clk);
  endtask

  task automatic clear_done();
    reg_wr(3'd5, 8'h01);
  endtask

  task automatic t_reset();
    logic [15:0] v; logic [7:0] s;
    rd16(3'd0, v); chk("R1 addr", v, 16'h0);
    rd16(3'd2, v); chk("R1 count", v, 16'h0);
    status(s); chk("R1 status", s, 8'h00);
    chk("R1 ready/done pins", {xfer_ready, xfer_done}, 2'b00);
    chk("R1 read data", dp_rdata, 16'h0);
  endtask

  task automatic t_load();
    logic [15:0] v;
    setup(16'h0123, 16'h0203);
    rd16(3'd0, v); chk("R2 addr readback", v, 16'h0123);
    rd16(3'd2, v); chk("R2 count readback", v, 16'h0203);
  endtask

  task automatic t_byte_write();
    logic [15:0] v; logic [7:0] s;
    word_mode = 1'b0;
    setup(16'h0040, 16'd3);
    reg_wr(3'd4, 8'h06);
    status(s); chk("R9 ready while active", s, 8'h02);
    chk("R9 ready pin", xfer_ready, 1'b1);
    dp_write(16'h77A1); dp_write(16'h77B2);
    rd16(3'd0, v); chk("R5 addr after 2 bytes", v, 16'h0042);
    rd16(3'd2, v); chk("R5 count after 2 bytes", v, 16'd1);
    dp_write(16'h77C3);
    status(s); chk("R6 done, not ready", s, 8'h01);
    chk("R6 done pin", xfer_done, 1'b1);
    rd16(3'd2, v); chk("R6 count zero", v, 16'd0);
    reg_wr(3'd5, 8'h00);
    status(s); chk("R7 write 0 keeps done", s, 8'h01);
    reg_wr(3'd5, 8'h01);
    status(s); chk("R7 write 1 clears done", s, 8'h00);
  endtask

  task automatic t_byte_read();
    logic [15:0] v; logic [7:0] s;
    setup(16'h0040, 16'd3);
    reg_wr(3'd4, 8'h05);
    dp_read(v); chk("R5 byte read 0", v, 16'h00A1);
    dp_read(v); chk("R5 byte read 1", v, 16'h00B2);
    dp_read(v); chk("R5 byte read 2", v, 16'h00C3);
    status(s); chk("R6 read done", s, 8'h01);
    clear_done();
  endtask

  task automatic t_ignored();
    logic [15:0] v;
    dp_rd = 1'b1; dp_wr = 1'b1; @(negedge clk); dp_rd = 1'b0; dp_wr = 1'b0;
    rd16(3'd0, v); chk("R8 idle access addr", v, 16'h0043);
    rd16(3'd2, v); chk("R8 idle access count", v, 16'd0);
    setup(16'h0080, 16'd2);
    reg_wr(3'd4, 8'h06);
    dp_rd = 1'b1; @(negedge clk); dp_rd = 1'b0;
    rd16(3'd0, v); chk("R8 wrong direction addr", v, 16'h0080);
    rd16(3'd2, v); chk("R8 wrong direction count", v, 16'd2);
    reg_wr(3'd4, 8'h00);
  endtask

  task automatic t_word();
    logic [15:0] v; logic [7:0] s;
    word_mode = 1'b1;
    setup(16'h0100, 16'd5);
    reg_wr(3'd4, 8'h06);
    rd16(3'd2, v); chk("R4 odd count rounded", v, 16'd6);
    dp_write(16'h1122); dp_write(16'h3344);
    rd16(3'd0, v); chk("R5 word addr step", v, 16'h0104);
    dp_write(16'h5566);
    status(s); chk("R6 word done", s, 8'h01);
    clear_done();
    setup(16'h0100, 16'd4);
    reg_wr(3'd4, 8'h05);
    dp_read(v); chk("R5 word read 0", v, 16'h1122);
    dp_read(v); chk("R5 word read 1", v, 16'h3344);
    clear_done();
    word_mode = 1'b0;
    setup(16'h0101, 16'd1);
    reg_wr(3'd4, 8'h05);
    dp_read(v); chk("R5 high lane at addr+1", v, 16'h0011);
    clear_done();
  endtask

  task automatic t_nostart();
    logic [15:0] v; logic [7:0] s;
    setup(16'h0100, 16'd2);
    reg_wr(3'd4, 8'h01);
    status(s); chk("R3 no start bit", s, 8'h00);
    dp_read(v);
    rd16(3'd0, v); chk("R3 no start addr held", v, 16'h0100);
  endtask

  task automatic t_abort();
    logic [15:0] v; logic [7:0] s;
    setup(16'h0100, 16'd4);
    reg_wr(3'd4, 8'h05);
    dp_read(v); chk("R5 first byte", v, 16'h0022);
    reg_wr(3'd0, 8'h55);
    rd16(3'd0, v); chk("R11 addr locked", v, 16'h0101);
    reg_wr(3'd4, 8'h00);
    status(s); chk("R10 abort idle, no done", s, 8'h00);
    rd16(3'd2, v); chk("R10 count kept", v, 16'd3);
    reg_wr(3'd4, 8'h05);
    reg_wr(3'd4, 8'h07);
    status(s); chk("R3 code 11 aborts", s, 8'h00);
  endtask

  task automatic t_zero();
    logic [7:0] s;
    setup(16'h0200, 16'd0);
    reg_wr(3'd4, 8'h06);
    status(s); chk("R6 zero count done at once", s, 8'h01);
    clear_done();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_byte_write();
    t_byte_read();
    t_ignored();
    t_word();
    t_nostart();
    t_abort();
    t_zero();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule